// File: doc/BRIEF.md
# Background and Sprite Pixel Priority Mux

This block sits at the end of a tile-based raster pipeline and turns the current background and sprite state into one 5-bit palette index per dot. Two 16-bit background pattern shifters and two 8-bit attribute shifters, each fed by a 1-bit latch, advance one bit per dot. A fine horizontal offset picks which bit of each shifter is the current pixel. Eight sprite slots each hold an X position, two pattern bytes and an attribute byte. Each slot is compared against the current pixel position, and the lowest-numbered opaque slot wins.

The block combines the two layers with a per-sprite behind-background bit. It applies left-edge clipping and layer enables. It keeps a sticky sprite-zero-hit flag, which never sets on the last column. When neither layer is enabled, the output shows either the palette entry that the current video address points at or the backdrop entry. The surrounding fetch logic drives the dot number, the line type, the fetched tile and attribute bytes and the current video address. It loads the sprite slots through a simple write port between lines. Palette lookup and color conversion happen downstream.

Top module: `pixel_priority_mux`

## Requirements
- R1: With the background enabled and unclipped, the background 2-bit pattern is {hi shifter bit (15 - fine_x), lo shifter bit (15 - fine_x)}. The attribute value is {attribute-hi bit (7 - fine_x), attribute-lo bit (7 - fine_x)}. An opaque background with no winning sprite gives index (attribute << 2) | pattern. A transparent pixel with no winning sprite gives index 0.
- R2: Shifting happens only when rendering is enabled on a visible or pre-render line, and only on dots 2 to 257 and 322 to 337. On each such dot, every shifter moves left by one bit. The attribute shifters take their latch bit in at bit 0. On a shifting dot whose value mod 8 is 1, the low byte of each pattern shifter is then replaced by `tile_lo` / `tile_hi`.
- R3: On a reload dot, the attribute latches take bits s and s+1 of `attr_byte`. Here s = {vaddr[6], (vaddr - 1)[1], 0}, so s is 0, 2, 4 or 6.
- R4: A slot covers pixel p when 0 <= p - X < 8. Its pattern is {hi[7 - (p - X)], lo[7 - (p - X)]}. Among covering slots with a nonzero pattern, the lowest-numbered one wins. A winning sprite gives index 0x10 + 4 * attr[1:0] + pattern.
- R5: A winning sprite whose attribute bit 5 is set yields to an opaque background, and the background index is output. If that bit is clear, or the background is transparent, the sprite index is output.
- R6: A disabled layer is transparent at every pixel. With its left-column enable low, a layer is transparent at pixels 0 to 7.
- R7: `s0_hit` sets when all of the following hold: rendering is on, slot 0 wins with a nonzero pattern, slot 0 was loaded with `spr_zero` = 1, the background pattern is nonzero, and the pixel is not 255. It then stays set until `hit_clr`. `hit_clr` clears it and takes priority over a set.
- R8: With both layers disabled, the index is vaddr[4:0] when vaddr[13:8] is all ones, and 0 otherwise. Bit 14 of vaddr is ignored.
- R9: The cycle after a visible-line dot d with 2 <= d <= 257, `pix_valid` is 1 and `pix_x` is d - 2. After any other dot, `pix_valid`, `pix_x` and `pix_idx` are 0.
- R10: After reset, all outputs are 0. All shifters, latches and sprite slots are cleared, so every sprite slot is transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| dot | input | 9 | Current dot number within the line |
| vis_line | input | 1 | Current line is a visible picture line |
| pre_line | input | 1 | Current line is the pre-render line |
| show_bg | input | 1 | Background layer enable |
| show_spr | input | 1 | Sprite layer enable |
| bg_left_on | input | 1 | Background visible in pixels 0-7 |
| spr_left_on | input | 1 | Sprites visible in pixels 0-7 |
| fine_x | input | 3 | Fine horizontal scroll |
| vaddr | input | 15 | Current video address |
| tile_lo | input | 8 | Fetched low pattern byte |
| tile_hi | input | 8 | Fetched high pattern byte |
| attr_byte | input | 8 | Fetched attribute byte |
| spr_we | input | 1 | Sprite slot write strobe |
| spr_sel | input | 3 | Sprite slot written |
| spr_x | input | 8 | Slot X position |
| spr_lo | input | 8 | Slot low pattern byte |
| spr_hi | input | 8 | Slot high pattern byte |
| spr_attr | input | 8 | Slot attributes (bits 1:0 palette, bit 5 behind) |
| spr_zero | input | 1 | Slot 0 holds sprite zero (sampled on slot 0 write) |
| hit_clr | input | 1 | Clears the sprite-zero-hit flag |
| pix_valid | output | 1 | Pixel output valid |
| pix_x | output | 8 | Pixel column |
| pix_idx | output | 5 | Palette index |
| s0_hit | output | 1 | Sticky sprite-zero-hit flag |

## Verification
Background lines are run with varying tile, attribute and address bytes at fine offsets 0, 3 and 7. These separate wrong bit selection, wrong reload timing and wrong attribute quadrant choice. A pre-render line followed by a visible line shows whether the 322-337 prefetch window shifts and reloads correctly. Overlapping sprites with transparent leading columns, plus a behind-background sprite over a mixed background, separate slot order from opacity and from priority. The sprite-zero cases at X = 254, X = 255 and a slot 0 without the zero flag tell the last-column exclusion apart from the flag qualification.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam int DOT_W   = 9;
    localparam int VADDR_W = 15;

    typedef struct packed {
        logic [7:0] xpos;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] attr;
    } spr_slot_t;

    typedef struct packed {
        logic [1:0] pat;
        logic [1:0] pal;
        logic       behind;
        logic       is_zero;
    } spr_px_t;

    typedef struct packed {
        logic [1:0] pat;
        logic [1:0] attr;
    } bg_px_t;

    function automatic logic in_shift_window(input logic [DOT_W-1:0] d);
        return ((d >= 9'd2) && (d <= 9'd257)) || ((d >= 9'd322) && (d <= 9'd337));
    endfunction

    function automatic logic [2:0] attr_shift_amt(input logic [VADDR_W-1:0] a);
        logic [VADDR_W-1:0] am1;
        am1 = a - 15'd1;
        return {a[6], am1[1], 1'b0};
    endfunction

    function automatic logic [4:0] compose_index(input bg_px_t bg, input spr_px_t sp);
        if ((sp.pat != 2'b00) && !(sp.behind && (bg.pat != 2'b00)))
            return {1'b1, sp.pal, sp.pat};
        else if (bg.pat == 2'b00)
            return 5'd0;
        else
            return {1'b0, bg.attr, bg.pat};
    endfunction

    function automatic logic [4:0] idle_index(input logic [VADDR_W-1:0] a);
        return (a[13:8] == 6'h3F) ? a[4:0] : 5'd0;
    endfunction

endpackage

// File: rtl/ppm_bg_shifter.sv
module ppm_bg_shifter
    import ppm_pkg::*;
#(
    parameter int PAT_W  = 16,
    parameter int ATTR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    input  logic               reload,
    input  logic [7:0]         tile_lo,
    input  logic [7:0]         tile_hi,
    input  logic [7:0]         attr_byte,
    input  logic [VADDR_W-1:0] vaddr,
    input  logic [2:0]         fine_x,
    output bg_px_t             px
);
    localparam int PAT_TOP  = PAT_W - 1;
    localparam int ATTR_TOP = ATTR_W - 1;

    logic [PAT_W-1:0]  pat_lo, pat_hi;
    logic [ATTR_W-1:0] at_lo, at_hi;
    logic              lat_lo, lat_hi;
    logic [2:0]        sel;

    assign sel = attr_shift_amt(vaddr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_lo <= '0;
            pat_hi <= '0;
            at_lo  <= '0;
            at_hi  <= '0;
            lat_lo <= 1'b0;
            lat_hi <= 1'b0;
        end else if (advance) begin
            at_lo <= {at_lo[ATTR_TOP-1:0], lat_lo};
            at_hi <= {at_hi[ATTR_TOP-1:0], lat_hi};
            if (reload) begin
                pat_lo <= {pat_lo[PAT_TOP-1:7], tile_lo};
                pat_hi <= {pat_hi[PAT_TOP-1:7], tile_hi};
                lat_lo <= attr_byte[sel];
                lat_hi <= attr_byte[sel + 3'd1];
            end else begin
                pat_lo <= {pat_lo[PAT_TOP-1:0], 1'b0};
                pat_hi <= {pat_hi[PAT_TOP-1:0], 1'b0};
            end
        end
    end

    always_comb begin
        px.pat  = {pat_hi[PAT_TOP - 32'(fine_x)], pat_lo[PAT_TOP - 32'(fine_x)]};
        px.attr = {at_hi[ATTR_TOP - 32'(fine_x)], at_lo[ATTR_TOP - 32'(fine_x)]};
    end

    AST_BG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(pat_lo) && $stable(pat_hi) && $stable(at_lo))) else $error("hold"); // R2
    AST_BG_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (advance && !reload) |=> (pat_lo[PAT_TOP:1] == $past(pat_lo[PAT_TOP-1:0]))) else $error("shift"); // R2
    AST_BG_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (advance && reload) |=> (pat_hi[7:0] == $past(tile_hi))) else $error("reload"); // R2

endmodule

// File: rtl/ppm_sprite_bank.sv
module ppm_sprite_bank
    import ppm_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int SEL_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  spr_slot_t        wdata,
    input  logic             zero_flag,
    input  logic [7:0]       pixel,
    input  logic             px_en,
    output spr_px_t          px
);
    spr_slot_t  slot [SLOTS];
    logic [1:0] cand [SLOTS];
    logic       zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b0;
        end else if (we && (sel == '0)) begin
            zero_q <= zero_flag;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [8:0] diff;
        logic [2:0] off;

        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (we && (sel == SEL_W'(i)))
                slot[i] <= wdata;
        end

        assign diff = {1'b0, pixel} - {1'b0, slot[i].xpos};
        assign off  = 3'd7 - diff[2:0];
        assign cand[i] = (diff < 9'd8) ? {slot[i].hi[off], slot[i].lo[off]} : 2'b00;
    end

    always_comb begin
        px = '0;
        if (px_en) begin
            for (int i = SLOTS - 1; i >= 0; i--) begin
                if (cand[i] != 2'b00) begin
                    px.pat     = cand[i];
                    px.pal     = slot[i].attr[1:0];
                    px.behind  = slot[i].attr[5];
                    px.is_zero = (i == 0) && zero_q;
                end
            end
        end
    end

    AST_SPR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && (sel == '0)) |=> (slot[0].xpos == $past(wdata.xpos))) else $error("slot write"); // R4

endmodule

// File: rtl/pixel_priority_mux.sv
module pixel_priority_mux
    import ppm_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int SEL_W = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DOT_W-1:0]   dot,
    input  logic               vis_line,
    input  logic               pre_line,
    input  logic               show_bg,
    input  logic               show_spr,
    input  logic               bg_left_on,
    input  logic               spr_left_on,
    input  logic [2:0]         fine_x,
    input  logic [VADDR_W-1:0] vaddr,
    input  logic [7:0]         tile_lo,
    input  logic [7:0]         tile_hi,
    input  logic [7:0]         attr_byte,
    input  logic               spr_we,
    input  logic [SEL_W-1:0]   spr_sel,
    input  logic [7:0]         spr_x,
    input  logic [7:0]         spr_lo,
    input  logic [7:0]         spr_hi,
    input  logic [7:0]         spr_attr,
    input  logic               spr_zero,
    input  logic               hit_clr,
    output logic               pix_valid,
    output logic [7:0]         pix_x,
    output logic [4:0]         pix_idx,
    output logic               s0_hit
);
    logic       render_on, advance, reload, out_dot;
    logic [7:0] pix_pos;
    logic       bg_vis, spr_vis, hit_now;
    bg_px_t     bg_raw, bg_eff;
    spr_px_t    spr;
    spr_slot_t  wslot;
    logic [4:0] idx_now;

    assign render_on = show_bg | show_spr;
    assign advance   = render_on && (vis_line || pre_line) && in_shift_window(dot);
    assign reload    = advance && (dot[2:0] == 3'd1);
    assign out_dot   = vis_line && (dot >= 9'd2) && (dot <= 9'd257);
    assign pix_pos   = 8'(dot - 9'd2);
    assign bg_vis    = show_bg  && (bg_left_on  || (pix_pos >= 8'd8));
    assign spr_vis   = show_spr && (spr_left_on || (pix_pos >= 8'd8));
    assign wslot     = '{xpos: spr_x, lo: spr_lo, hi: spr_hi, attr: spr_attr};

    ppm_bg_shifter u_bg (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .reload   (reload),
        .tile_lo  (tile_lo),
        .tile_hi  (tile_hi),
        .attr_byte(attr_byte),
        .vaddr    (vaddr),
        .fine_x   (fine_x),
        .px       (bg_raw)
    );

    ppm_sprite_bank #(.SLOTS(SLOTS)) u_spr (
        .clk      (clk),
        .rst      (rst),
        .we       (spr_we),
        .sel      (spr_sel),
        .wdata    (wslot),
        .zero_flag(spr_zero),
        .pixel    (pix_pos),
        .px_en    (spr_vis),
        .px       (spr)
    );

    always_comb begin
        bg_eff     = bg_raw;
        if (!bg_vis) bg_eff.pat = 2'b00;
        idx_now    = render_on ? compose_index(bg_eff, spr) : idle_index(vaddr);
        hit_now    = render_on && (spr.pat != 2'b00) && spr.is_zero
                     && (bg_eff.pat != 2'b00) && (pix_pos != 8'hFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_x     <= '0;
            pix_idx   <= '0;
            s0_hit    <= 1'b0;
        end else begin
            pix_valid <= out_dot;
            pix_x     <= out_dot ? pix_pos : 8'd0;
            pix_idx   <= out_dot ? idx_now : 5'd0;
            if (hit_clr)
                s0_hit <= 1'b0;
            else if (out_dot && hit_now)
                s0_hit <= 1'b1;
        end
    end

    AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> ($past(vis_line) && ($past(dot) >= 9'd2) && ($past(dot) <= 9'd257))) else $error("window"); // R9
    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (s0_hit && !hit_clr) |=> s0_hit) else $error("sticky"); // R7
    AST_HIT_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(s0_hit) |-> (pix_valid && (pix_x != 8'hFF))) else $error("last column"); // R7
    AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !$past(show_bg) && !$past(show_spr) && ($past(vaddr[13:8]) != 6'h3F))
        |-> (pix_idx == 5'd0)) else $error("idle index"); // R8

endmodule

// File: tb/tb_pixel_priority_mux.sv
`timescale 1ns/1ps
module tb_pixel_priority_mux;

    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  dot;
    logic        vis_line, pre_line, show_bg, show_spr, bg_left_on, spr_left_on;
    logic [2:0]  fine_x;
    logic [14:0] vaddr;
    logic [7:0]  tile_lo, tile_hi, attr_byte;
    logic        spr_we;
    logic [2:0]  spr_sel;
    logic [7:0]  spr_x, spr_lo, spr_hi, spr_attr;
    logic        spr_zero, hit_clr;
    logic        pix_valid;
    logic [7:0]  pix_x;
    logic [4:0]  pix_idx;
    logic        s0_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [15:0] m_plo, m_phi;
    logic [7:0]  m_alo, m_ahi;
    logic        m_llo, m_lhi;
    logic [7:0]  m_x [8];
    logic [7:0]  m_lo [8];
    logic [7:0]  m_hi [8];
    logic [7:0]  m_at [8];
    logic        m_zero, m_hit;

    // stimulus generator controls
    int    seed;
    int    vmode;   // 0: scrambled address, 1: palette-range / other address
    bit    flat;    // constant opaque background
    string cur_req;

    always #4 clk = ~clk;

    pixel_priority_mux dut (
        .clk(clk), .rst(rst), .dot(dot), .vis_line(vis_line), .pre_line(pre_line),
        .show_bg(show_bg), .show_spr(show_spr), .bg_left_on(bg_left_on),
        .spr_left_on(spr_left_on), .fine_x(fine_x), .vaddr(vaddr),
        .tile_lo(tile_lo), .tile_hi(tile_hi), .attr_byte(attr_byte),
        .spr_we(spr_we), .spr_sel(spr_sel), .spr_x(spr_x), .spr_lo(spr_lo),
        .spr_hi(spr_hi), .spr_attr(spr_attr), .spr_zero(spr_zero), .hit_clr(hit_clr),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_idx(pix_idx), .s0_hit(s0_hit)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_plo = '0; m_phi = '0; m_alo = '0; m_ahi = '0; m_llo = 0; m_lhi = 0;
        for (int i = 0; i < 8; i++) begin
            m_x[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_at[i] = 0;
        end
        m_zero = 0; m_hit = 0;
    endtask

    task automatic idle_inputs();
        dot = 9'd300; vis_line = 0; pre_line = 0; vaddr = '0;
        tile_lo = 0; tile_hi = 0; attr_byte = 0;
        spr_we = 0; spr_sel = 0; spr_x = 0; spr_lo = 0; spr_hi = 0; spr_attr = 0;
        spr_zero = 0; hit_clr = 0;
    endtask

    // One dot: drive, predict, advance model, check after the edge.
    task automatic dot_cycle(input int d, input bit vis, input bit pre);
        int p, off, sel;
        bit exp_valid, render, bgv, spv, hit_now, found, sbeh;
        logic [1:0] bgp, bga, spp, spal;
        logic [4:0] exp_idx;
        logic [14:0] vm1;
        dot = 9'(d); vis_line = vis; pre_line = pre;
        if (flat) begin
            tile_lo = 8'hFF; tile_hi = 8'h00; attr_byte = 8'h00;
        end else begin
            tile_lo = 8'(d * 7 + seed); tile_hi = 8'((d * 11) ^ seed); attr_byte = 8'(d * 29 + seed);
        end
        if (vmode == 0) vaddr = 15'(d * 41 + seed * 3);
        else if (d % 3 == 0) vaddr = 15'h3F00 | 15'(d);
        else if (d % 3 == 1) vaddr = 15'h7F00 | 15'(d);
        else vaddr = 15'h2000 + 15'(d);
        p = d - 2;
        exp_valid = vis && d >= 2 && d <= 257;
        render = show_bg | show_spr;
        hit_now = 0;
        if (!render) begin
            exp_idx = (vaddr[13:8] == 6'h3F) ? vaddr[4:0] : 5'd0;
        end else begin
            bgv = show_bg && (bg_left_on || p >= 8);
            spv = show_spr && (spr_left_on || p >= 8);
            bgp = bgv ? {m_phi[15 - fine_x], m_plo[15 - fine_x]} : 2'b00;
            bga = {m_ahi[7 - fine_x], m_alo[7 - fine_x]};
            found = 0; spp = 0; spal = 0; sbeh = 0;
            if (spv) begin
                for (int i = 0; i < 8; i++) begin
                    off = p - int'(m_x[i]);
                    if (!found && off >= 0 && off < 8 &&
                        {m_hi[i][7 - off], m_lo[i][7 - off]} != 2'b00) begin
                        found = 1;
                        spp = {m_hi[i][7 - off], m_lo[i][7 - off]};
                        spal = m_at[i][1:0];
                        sbeh = m_at[i][5];
                        hit_now = (i == 0) && m_zero;
                    end
                end
            end
            hit_now = hit_now && (bgp != 0) && (p != 255);
            if (found && !(sbeh && bgp != 0)) exp_idx = {1'b1, spal, spp};
            else if (bgp == 0) exp_idx = 0;
            else exp_idx = {1'b0, bga, bgp};
        end
        if (render && (vis || pre) && ((d >= 2 && d <= 257) || (d >= 322 && d <= 337))) begin
            m_alo = {m_alo[6:0], m_llo};
            m_ahi = {m_ahi[6:0], m_lhi};
            if (d % 8 == 1) begin
                m_plo = {m_plo[14:7], tile_lo};
                m_phi = {m_phi[14:7], tile_hi};
                vm1 = vaddr - 15'd1;
                sel = {vaddr[6], vm1[1], 1'b0};
                m_llo = attr_byte[sel];
                m_lhi = attr_byte[sel + 1];
            end else begin
                m_plo = m_plo << 1;
                m_phi = m_phi << 1;
            end
        end
        if (hit_clr) m_hit = 0;
        else if (exp_valid && hit_now) m_hit = 1;
        @(posedge clk); #2;
        check("R9", $sformatf("valid dot %0d", d), int'(pix_valid), int'(exp_valid));
        check("R9", $sformatf("pix_x dot %0d", d), int'(pix_x), exp_valid ? p : 0);
        check(cur_req, $sformatf("index dot %0d", d), int'(pix_idx), exp_valid ? int'(exp_idx) : 0);
        check("R7", $sformatf("hit flag dot %0d", d), int'(s0_hit), int'(m_hit));
        @(negedge clk);
    endtask

    task automatic run_line(input bit vis, input bit pre);
        for (int d = 0; d <= 340; d++) dot_cycle(d, vis, pre);
        idle_inputs();
    endtask

    task automatic load_slot(input int s, input logic [7:0] x, input logic [7:0] lo,
                             input logic [7:0] hi, input logic [7:0] at, input bit z);
        idle_inputs();
        spr_we = 1; spr_sel = 3'(s); spr_x = x; spr_lo = lo; spr_hi = hi; spr_attr = at; spr_zero = z;
        m_x[s] = x; m_lo[s] = lo; m_hi[s] = hi; m_at[s] = at;
        if (s == 0) m_zero = z;
        @(posedge clk); #2;
        check("R4", "no pixel during slot load", int'(pix_valid), 0);
        @(negedge clk);
        spr_we = 0;
    endtask

    task automatic clear_hit();
        idle_inputs();
        hit_clr = 1; m_hit = 0;
        @(posedge clk); #2;
        check("R7", "hit cleared by hit_clr", int'(s0_hit), 0);
        @(negedge clk);
        hit_clr = 0;
    endtask

    task automatic test_reset();
        cur_req = "R10";
        check("R10", "pix_valid after reset", int'(pix_valid), 0);
        check("R10", "pix_idx after reset", int'(pix_idx), 0);
        check("R10", "pix_x after reset", int'(pix_x), 0);
        check("R10", "s0_hit after reset", int'(s0_hit), 0);
        // cleared slots transparent, shifters empty: all-zero line
        show_bg = 1; show_spr = 1; bg_left_on = 1; spr_left_on = 1; fine_x = 0;
        for (int d = 0; d < 12; d++) dot_cycle(d, 1, 0);
        idle_inputs();
    endtask

    task automatic test_background();
        show_bg = 1; show_spr = 0; bg_left_on = 1; spr_left_on = 1; vmode = 0; flat = 0;
        cur_req = "R1"; fine_x = 0; seed = 3;  run_line(1, 0);
        cur_req = "R3"; fine_x = 3; seed = 90; run_line(1, 0);
        cur_req = "R1"; fine_x = 7; seed = 17; run_line(1, 0);
    endtask

    task automatic test_prefetch();
        show_bg = 1; show_spr = 0; bg_left_on = 1; fine_x = 2; vmode = 0; flat = 0;
        cur_req = "R2"; seed = 55;
        run_line(0, 1);
        run_line(1, 0);
    endtask

    task automatic test_sprites();
        show_bg = 1; show_spr = 1; bg_left_on = 1; spr_left_on = 1; fine_x = 1; vmode = 0; flat = 0;
        load_slot(0, 8'd20,  8'h0F, 8'h00, 8'h01, 0);
        load_slot(1, 8'd18,  8'hFF, 8'hFF, 8'h02, 0);
        load_slot(2, 8'd100, 8'hAA, 8'h55, 8'h23, 0);
        load_slot(3, 8'd102, 8'hFF, 8'h00, 8'h00, 0);
        load_slot(7, 8'd200, 8'hC3, 8'h3C, 8'h03, 0);
        cur_req = "R4"; seed = 8;  run_line(1, 0);
        cur_req = "R5"; seed = 71; run_line(1, 0);
    endtask

    task automatic test_clip();
        vmode = 0; flat = 0; fine_x = 0; seed = 33;
        load_slot(0, 8'd0, 8'hFF, 8'hFF, 8'h00, 0);
        load_slot(1, 8'd4, 8'hFF, 8'h00, 8'h01, 0);
        show_bg = 1; show_spr = 1; bg_left_on = 0; spr_left_on = 0;
        cur_req = "R6"; run_line(1, 0);
        show_bg = 0; show_spr = 1; bg_left_on = 1; spr_left_on = 1;
        run_line(1, 0);
        show_bg = 1; show_spr = 0; spr_left_on = 0; bg_left_on = 0;
        run_line(1, 0);
    endtask

    task automatic test_hit();
        show_bg = 1; show_spr = 1; bg_left_on = 1; spr_left_on = 1; fine_x = 0; vmode = 0; flat = 1;
        for (int i = 1; i < 8; i++) load_slot(i, 8'd0, 8'h00, 8'h00, 8'h00, 0);
        cur_req = "R7";
        load_slot(0, 8'd254, 8'hFF, 8'h00, 8'h00, 1);
        run_line(1, 0);
        check("R7", "hit set at column 254", int'(s0_hit), 1);
        clear_hit();
        load_slot(0, 8'd255, 8'hFF, 8'h00, 8'h00, 1);
        run_line(1, 0);
        check("R7", "no hit at column 255", int'(s0_hit), 0);
        load_slot(0, 8'd50, 8'hFF, 8'h00, 8'h00, 0);
        run_line(1, 0);
        check("R7", "no hit without zero flag", int'(s0_hit), 0);
        flat = 0;
    endtask

    task automatic test_render_off();
        show_bg = 0; show_spr = 0; vmode = 1; flat = 0; seed = 5;
        cur_req = "R8";
        run_line(1, 0);
        vmode = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        show_bg = 0; show_spr = 0; bg_left_on = 0; spr_left_on = 0; fine_x = 0;
        seed = 0; vmode = 0; flat = 0; cur_req = "R10";
        model_clear();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        test_reset();
        test_background();
        test_prefetch();
        test_sprites();
        test_clip();
        test_hit();
        test_render_off();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule